// File: doc/BRIEF.md
# Subroutine Return Stack with Reserved Frame Slots

This block is the hardware program stack of a small processor. It holds values pushed by software, hands them back on pops, and carries the return addresses of subroutine calls. An instruction decoder outside the block issues one operation per clock on `op_i`. Push data comes from an immediate or a register. The call operation supplies the current program counter and the call target. The stack grows upward in a 16-entry internal array. `sp_o` always points at the next free entry.

The calling sequence uses a frame mark. A mark operation reserves the return-address slot first and remembers its index. Any parameters for the callee are pushed next. The call then writes PC+1 into the reserved slot, below the parameters, so the callee's first pop yields the last parameter and not the return address. A return reads the address from the reserved slot and drops SP back to that slot's index, which discards any leftovers. It also restores the enclosing frame, so calls can nest.

Faulting operations change no state and raise `err_o` for one cycle. Faulting operations are a pop or return with nothing to take, a push or mark on a full stack, and a call or return with no live frame. Results are registered and show at the ports one cycle after the operation.

Top module: `frame_call_stack`

## Requirements
- R1: After reset `sp_o`, `pop_data_o`, `next_pc_o` and `err_o` are all 0; op code 0 (no-op) leaves every output as it was apart from clearing `err_o`.
- R2: A push (op code 1) on a non-full stack stores `push_data_i` at entry SP and increments `sp_o` by one.
- R3: A pop (op code 2) on a non-empty stack presents the top entry on `pop_data_o` and decrements `sp_o`, giving last-in first-out order.
- R4: A pop when `sp_o` is 0 sets `err_o` and leaves `sp_o` and `pop_data_o` unchanged.
- R5: A push when `sp_o` is 16 sets `err_o`, leaves `sp_o` at 16 and leaves the stored entries intact.
- R6: A mark (op code 3) on a non-full stack reserves entry SP as the frame slot and increments `sp_o` with no error.
- R7: A call (op code 4) with a live frame sets `next_pc_o` to `target_i` and leaves `sp_o` unchanged.
- R8: Values pushed between a mark and its call are popped by the callee in last-in first-out order, before the return address is reached.
- R9: A return (op code 5) sets `next_pc_o` to the calling `pc_i` + 1 and sets `sp_o` to the frame slot index, discarding any entries above the slot.
- R10: Nested mark/call pairs return in reverse order, each return restoring the enclosing frame.
- R11: A call or return with no live frame sets `err_o` and changes neither `sp_o` nor `next_pc_o`. A frame is live when a frame exists and its slot index is below `sp_o`.
- R12: `err_o` is high only in the cycle after a faulting operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation: 0 none, 1 push, 2 pop, 3 mark, 4 call, 5 return |
| push_data_i | input | 16 | Value to push |
| pc_i | input | 16 | Address of the call instruction |
| target_i | input | 16 | Subroutine address for a call |
| pop_data_o | output | 16 | Value taken by the last pop |
| sp_o | output | 5 | Stack pointer, next free entry (0 to 16) |
| next_pc_o | output | 16 | Program counter to load after a call or return |
| err_o | output | 1 | Underflow, overflow or missing-frame fault |

## Verification
A corrupted SP or frame index shows at the ports one cycle after it occurs. It appears either on `sp_o` directly or as a wrong value on the next pop or return. A slot that was overwritten, or a return address written to the wrong entry, stays hidden until the return that reads it. For that reason the sequences pop every parameter and return at several depths, and they also nest frames. Fault handling is checked at both the empty and the full boundary. In each case a later pop or return confirms that the stored contents survived.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_MARK = 3'd3,
    OP_CALL = 3'd4,
    OP_RET  = 3'd5
  } op_e;
endpackage

// File: rtl/fcs_store.sv
module fcs_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         mem_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))  mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fcs_frame.sv
module fcs_frame #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mark_i,
  input  logic          ret_i,
  input  logic [AW-1:0] slot_i,
  output logic [AW:0]   frame_o
);
  localparam logic [AW:0] NONE = (AW+1)'(DEPTH);

  logic [AW:0] frame_q;
  logic [AW:0] link_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= NONE;
      for (int i = 0; i < DEPTH; i++) link_q[i] <= NONE;
    end else if (mark_i) begin
      link_q[slot_i] <= frame_q;
      frame_q        <= {1'b0, slot_i};
    end else if (ret_i) begin
      frame_q <= link_q[frame_q[AW-1:0]];
    end
  end

  assign frame_o = frame_q;

  a_r10_frame_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_q <= NONE);
  a_r6_mark_sets_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_i |=> frame_o == {1'b0, $past(slot_i)});
endmodule

// File: rtl/frame_call_stack.sv
module frame_call_stack #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] push_data_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] target_i,
  output logic [DW-1:0] pop_data_o,
  output logic [AW:0]   sp_o,
  output logic [DW-1:0] next_pc_o,
  output logic          err_o
);
  import fcs_pkg::*;

  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  op_e           op;
  logic [AW:0]   sp_q, sp_d, sp_m1, frame;
  logic [DW-1:0] pop_q, pop_d, npc_q, npc_d, rdata, wdata;
  logic [AW-1:0] waddr, raddr;
  logic          err_q, err_d, we, mark, ret;
  logic          full, empty, live;

  assign op    = op_e'(op_i);
  assign full  = sp_q == FULL;
  assign empty = sp_q == '0;
  assign live  = frame < sp_q;
  assign sp_m1 = sp_q - 1'b1;
  assign raddr = (op == OP_RET) ? frame[AW-1:0] : sp_m1[AW-1:0];

  always_comb begin
    sp_d  = sp_q;
    pop_d = pop_q;
    npc_d = npc_q;
    err_d = 1'b0;
    we    = 1'b0;
    waddr = sp_q[AW-1:0];
    wdata = push_data_i;
    mark  = 1'b0;
    ret   = 1'b0;
    unique case (op)
      OP_PUSH: if (full) err_d = 1'b1;
               else begin we = 1'b1; sp_d = sp_q + 1'b1; end
      OP_POP:  if (empty) err_d = 1'b1;
               else begin pop_d = rdata; sp_d = sp_m1; end
      OP_MARK: if (full) err_d = 1'b1;
               else begin
                 we = 1'b1; wdata = '0; mark = 1'b1; sp_d = sp_q + 1'b1;
               end
      OP_CALL: if (!live) err_d = 1'b1;
               else begin
                 we = 1'b1; waddr = frame[AW-1:0]; wdata = pc_i + DW'(1);
                 npc_d = target_i;
               end
      OP_RET:  if (!live) err_d = 1'b1;
               else begin npc_d = rdata; sp_d = frame; ret = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      pop_q <= '0;
      npc_q <= '0;
      err_q <= 1'b0;
    end else begin
      sp_q  <= sp_d;
      pop_q <= pop_d;
      npc_q <= npc_d;
      err_q <= err_d;
    end
  end

  fcs_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  fcs_frame #(.DEPTH(DEPTH)) u_frame (
    .clk_i, .rst_ni, .mark_i(mark), .ret_i(ret),
    .slot_i(sp_q[AW-1:0]), .frame_o(frame)
  );

  assign sp_o       = sp_q;
  assign pop_data_o = pop_q;
  assign next_pc_o  = npc_q;
  assign err_o      = err_q;

  a_r5_sp_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_o <= FULL);
  a_r2_push_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && sp_o != FULL) |=> sp_o == $past(sp_o) + 1'b1);
  a_r4_pop_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 && sp_o == '0) |=> err_o && sp_o == '0);
  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && sp_o == FULL) |=> err_o && $stable(sp_o));
  a_r7_call_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4 && frame < sp_o) |=> next_pc_o == $past(target_i) && $stable(sp_o));
  a_r9_ret_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd5 && frame < sp_o) |=> sp_o == $past(frame));
  a_r11_no_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == 3'd4 || op_i == 3'd5) && !(frame < sp_o)) |=> err_o && $stable(next_pc_o));
endmodule

// File: tb/frame_call_stack_tb.sv
`timescale 1ns/1ps
module frame_call_stack_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [15:0] pdata = '0, pc = '0, tgt = '0;
  logic [15:0] pop_data, next_pc;
  logic [4:0]  sp;
  logic        err;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frame_call_stack u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .push_data_i(pdata),
    .pc_i(pc), .target_i(tgt), .pop_data_o(pop_data), .sp_o(sp),
    .next_pc_o(next_pc), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, result visible after the next posedge
  task automatic do_op(input logic [2:0] o, input logic [15:0] d,
                       input logic [15:0] p, input logic [15:0] t);
    @(negedge clk);
    op = o; pdata = d; pc = p; tgt = t;
    @(posedge clk); #1;
    op = 3'd0;
  endtask

  function automatic logic [15:0] val(input int i);
    return 16'(16'h1000 + i * 37);
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sp", sp, 0); chk("R1 pop", pop_data, 0);
    chk("R1 npc", next_pc, 0); chk("R1 err", err, 0);

    do_op(3'd2, 0, 0, 0);
    chk("R4 err", err, 1); chk("R4 sp", sp, 0); chk("R4 pop", pop_data, 0);
    do_op(3'd0, 0, 0, 0);
    chk("R12 err clear", err, 0); chk("R1 nop sp", sp, 0);

    for (int i = 0; i < 16; i++) begin
      do_op(3'd1, val(i), 0, 0);
      chk("R2 sp", sp, i + 1); chk("R2 err", err, 0);
    end
    do_op(3'd1, 16'hdead, 0, 0);
    chk("R5 err", err, 1); chk("R5 sp", sp, 16);
    do_op(3'd3, 0, 0, 0);
    chk("R5 mark full err", err, 1); chk("R5 mark full sp", sp, 16);
    for (int i = 15; i >= 0; i--) begin
      do_op(3'd2, 0, 0, 0);
      chk("R3 data", pop_data, val(i)); chk("R3 sp", sp, i); chk("R12 err", err, 0);
    end
    do_op(3'd2, 0, 0, 0);
    chk("R4 err", err, 1); chk("R4 pop kept", pop_data, val(0));

    do_op(3'd5, 0, 0, 0);
    chk("R11 ret err", err, 1); chk("R11 ret sp", sp, 0);
    do_op(3'd4, 0, 16'h0040, 16'h0300);
    chk("R11 call err", err, 1); chk("R11 call npc", next_pc, 0);

    for (int k = 0; k < 5; k++) begin
      logic [15:0] p = 16'(100 + 7 * k);
      do_op(3'd1, 16'h00aa, 0, 0); // filler under the frame
      do_op(3'd3, 0, 0, 0);
      chk("R6 sp", sp, 2); chk("R6 err", err, 0);
      for (int j = 0; j < k; j++) do_op(3'd1, 16'(16'h0500 + 16 * k + j), 0, 0);
      do_op(3'd4, 0, p, 16'(16'h0200 + k));
      chk("R7 npc", next_pc, 16'h0200 + k); chk("R7 sp", sp, 2 + k);
      if (k != 4) begin
        for (int j = k - 1; j >= 0; j--) begin
          do_op(3'd2, 0, 0, 0);
          chk("R8 param", pop_data, 16'h0500 + 16 * k + j);
        end
      end
      do_op(3'd5, 0, 0, 0);
      chk("R9 npc", next_pc, p + 1); chk("R9 sp", sp, 1); chk("R9 err", err, 0);
      do_op(3'd2, 0, 0, 0);
      chk("R9 below frame", pop_data, 16'h00aa);
    end

    do_op(3'd3, 0, 0, 0);
    do_op(3'd4, 0, 16'd10, 16'd50);
    do_op(3'd3, 0, 0, 0);
    do_op(3'd1, 16'h0077, 0, 0);
    do_op(3'd4, 0, 16'd60, 16'd90);
    chk("R10 inner npc", next_pc, 90); chk("R10 sp", sp, 3);
    do_op(3'd2, 0, 0, 0);
    chk("R10 param", pop_data, 16'h0077);
    do_op(3'd5, 0, 0, 0);
    chk("R10 inner ret", next_pc, 61); chk("R10 inner sp", sp, 1);
    do_op(3'd5, 0, 0, 0);
    chk("R10 outer ret", next_pc, 11); chk("R10 outer sp", sp, 0);
    do_op(3'd5, 0, 0, 0);
    chk("R11 extra ret err", err, 1); chk("R11 extra ret npc", next_pc, 11);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule